// File: doc/BRIEF.md
# Double-Buffered Histogram Accumulator

This block counts binned events into a histogram of saturating 16-bit counters. It also reads out the previous measurement cycle's histogram at the same time. Two memory banks take turns. The active bank receives one read-modify-write increment for each accepted event. The frozen bank holds the histogram of the last finished cycle. A pulse on `cycle_swap` marks each cycle boundary and exchanges the roles of the two banks.

After a swap, the block scans the frozen bank once for each enabled product. Each product keeps the upper bits of the bin address as its output index. It sums the counts over the remaining lower bits. The block emits one 24-bit sum per index on a registered stream. The last scan pass also writes zero behind the read pointer, so the bank is empty when it becomes active again. After reset, both banks are cleared over 1024 cycles. Events offered during that time are not counted.

Top module: `hist_pingpong_acc`

## Requirements
- R1: Each accepted event (`ev_valid` high) adds one to the counter selected by `ev_bin` in the active bank.
- R2: Events offered on consecutive cycles, including repeats of one address and alternating addresses, are all counted. None is lost.
- R3: A counter that holds 0xFFFF stays at 0xFFFF on further events.
- R4: A `cycle_swap` accepted while the block is idle freezes the active bank and makes the other bank active. An event offered in the same cycle as the swap is counted into the bank being frozen.
- R5: The enabled products are emitted in ascending product number, each with its indices in ascending order. Product p keeps the top k bits of the bin address as the index, where k is `prod_keep[p*4 +: 4]` and values above 10 act as 10. Its sum covers every counter sharing that index. `out_last` is high only on the final index of a product.
- R6: The products are enabled independently by `prod_enable`, captured at the swap. A disabled product emits nothing. With no product enabled, the stream stays silent.
- R7: After a readout, every counter of the frozen bank is zero when that bank next becomes active.
- R8: Events accepted while the frozen bank is being scanned or cleared are counted in the active bank and do not change the products being emitted.
- R9: A `cycle_swap` that arrives before the previous readout and clear have finished is ignored. The readout continues unchanged and the active bank keeps filling.
- R10: After reset, `out_valid` is low, and the first readout of each bank shows all counters at zero apart from counted events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_bin | input | 10 | Bin address of the event |
| cycle_swap | input | 1 | Measurement-cycle boundary pulse |
| prod_enable | input | 2 | Enable bit per product, captured at swap |
| prod_keep | input | 8 | Kept-field width per product, 4 bits each, captured at swap |
| out_valid | output | 1 | Product word valid |
| out_prod | output | 2 | Product number of the word |
| out_index | output | 10 | Kept index of the word |
| out_sum | output | 24 | Sum over the summed field, saturating |
| out_last | output | 1 | Final word of the product |

## Verification
Two pairs of functions can fall in the same cycle. The first is an increment and a bank swap. The bench offers an event in the very cycle of the swap, and it judges the result by finding that count in the readout of the bank just frozen. The second is an increment into the active bank while the clear pass writes zeros into the frozen bank. The bench streams events throughout a readout. It then requires both that the current products match the frozen contents and that the next readout holds exactly the events that arrived during the scan.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_SCAN  = 2'd3
  } hst_state_e;

endpackage

// File: rtl/hist_bank_ram.sv
module hist_bank_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first: a read and a write to one address return the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_rmw.sv
module hist_rmw #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [AW-1:0] in_addr,
  input  logic          in_bank,
  input  logic [DW-1:0] rd_data,
  output logic          wr_v,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          s1_v, s1_bank;
  logic [AW-1:0] s1_addr;
  logic          fw_v, fw_bank;
  logic [AW-1:0] fw_addr;
  logic [DW-1:0] fw_data;
  logic [DW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_bank <= 1'b0;
      s1_addr <= '0;
      fw_v    <= 1'b0;
      fw_bank <= 1'b0;
      fw_addr <= '0;
      fw_data <= '0;
    end else begin
      s1_v    <= in_v;
      s1_bank <= in_bank;
      s1_addr <= in_addr;
      fw_v    <= s1_v;
      fw_bank <= s1_bank;
      fw_addr <= s1_addr;
      fw_data <= wr_data;
    end
  end

  // the write issued on the previous edge is not yet visible to this read
  always_comb begin
    if (fw_v && fw_bank == s1_bank && fw_addr == s1_addr) base = fw_data;
    else                                                   base = rd_data;
    wr_data = (&base) ? base : base + DW'(1);
  end

  assign wr_v    = s1_v;
  assign wr_bank = s1_bank;
  assign wr_addr = s1_addr;
endmodule

// File: rtl/hist_reducer.sv
module hist_reducer #(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int SUM_W = 24,
  parameter int KW    = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_v,
  input  logic [AW-1:0]    rd_addr,
  input  logic [PW-1:0]    rd_prod,
  input  logic [KW-1:0]    rd_sumw,
  input  logic [DW-1:0]    rdata,
  output logic             out_valid,
  output logic [PW-1:0]    out_prod,
  output logic [AW-1:0]    out_index,
  output logic [SUM_W-1:0] out_sum,
  output logic             out_last
);
  logic             a_v;
  logic [AW-1:0]    a_addr;
  logic [PW-1:0]    a_prod;
  logic [KW-1:0]    a_sumw;
  logic [SUM_W-1:0] acc;

  logic [KW-1:0]    sh;
  logic [AW-1:0]    lowmask, low;
  logic             g_first, g_last;
  logic [SUM_W:0]   wide;
  logic [SUM_W-1:0] sat;

  always_comb begin
    sh      = KW'(AW) - a_sumw;
    lowmask = {AW{1'b1}} >> sh;
    low     = a_addr & lowmask;
    g_first = (low == '0);
    g_last  = (low == lowmask);
    wide    = {1'b0, (g_first ? {SUM_W{1'b0}} : acc)} + {{(SUM_W + 1 - DW){1'b0}}, rdata};
    sat     = wide[SUM_W] ? {SUM_W{1'b1}} : wide[SUM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v       <= 1'b0;
      a_addr    <= '0;
      a_prod    <= '0;
      a_sumw    <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_prod  <= '0;
      out_index <= '0;
      out_sum   <= '0;
      out_last  <= 1'b0;
    end else begin
      a_v       <= rd_v;
      a_addr    <= rd_addr;
      a_prod    <= rd_prod;
      a_sumw    <= rd_sumw;
      if (a_v) acc <= sat;
      out_valid <= a_v && g_last;
      out_prod  <= a_prod;
      out_index <= a_addr >> a_sumw;
      out_sum   <= sat;
      out_last  <= a_v && g_last && (&a_addr);
    end
  end
endmodule

// File: rtl/hist_pingpong_acc.sv
module hist_pingpong_acc
  import hist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16,
  parameter int SUM_W  = 24,
  parameter int NPROD  = 2,
  localparam int KW    = $clog2(ADDR_W + 1),
  localparam int PW    = $clog2(NPROD + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_valid,
  input  logic [ADDR_W-1:0]   ev_bin,
  input  logic                cycle_swap,
  input  logic [NPROD-1:0]    prod_enable,
  input  logic [NPROD*KW-1:0] prod_keep,
  output logic                out_valid,
  output logic [PW-1:0]       out_prod,
  output logic [ADDR_W-1:0]   out_index,
  output logic [SUM_W-1:0]    out_sum,
  output logic                out_last
);
  hst_state_e          st;
  logic                act_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [PW-1:0]       prod_q;
  logic [NPROD-1:0]    en_q;
  logic [NPROD*KW-1:0] keep_q;

  logic                ev_take, swap_take, addr_last, is_last, emit, clr_we;
  logic [PW-1:0]       nxt_prod, start_prod;
  logic [KW-1:0]       cur_keep, keep_cl, cur_sumw;

  logic                wr_v, wr_bank;
  logic [ADDR_W-1:0]   wr_addr;
  logic [CNT_W-1:0]    wr_data;
  logic [1:0][CNT_W-1:0] bank_q;

  function automatic logic [PW-1:0] first_from(input logic [NPROD-1:0] en, input int from);
    logic [PW-1:0] r;
    r = PW'(NPROD);
    for (int p = NPROD - 1; p >= 0; p--)
      if (p >= from && en[p]) r = PW'(p);
    return r;
  endfunction

  always_comb begin
    ev_take    = ev_valid && (st != ST_INIT);
    swap_take  = cycle_swap && (st == ST_IDLE);
    addr_last  = &addr_q;
    nxt_prod   = first_from(en_q, int'(prod_q) + 1);
    start_prod = first_from(prod_enable, 0);
    is_last    = (nxt_prod == PW'(NPROD));
    emit       = (st == ST_SCAN) && (prod_q != PW'(NPROD));
    clr_we     = (st == ST_INIT) || ((st == ST_SCAN) && is_last);
    cur_keep   = '0;
    for (int p = 0; p < NPROD; p++)
      if (prod_q == PW'(p)) cur_keep = keep_q[p*KW +: KW];
    keep_cl    = (cur_keep > KW'(ADDR_W)) ? KW'(ADDR_W) : cur_keep;
    cur_sumw   = KW'(ADDR_W) - keep_cl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_INIT;
      act_q  <= 1'b0;
      addr_q <= '0;
      prod_q <= '0;
      en_q   <= '0;
      keep_q <= '0;
    end else begin
      unique case (st)
        ST_INIT: begin
          addr_q <= addr_q + 1'b1;
          if (addr_last) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (swap_take) begin
            act_q  <= ~act_q;
            en_q   <= prod_enable;
            keep_q <= prod_keep;
            prod_q <= start_prod;
            st     <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          addr_q <= '0;
          st     <= ST_SCAN;
        end
        ST_SCAN: begin
          addr_q <= addr_q + 1'b1;
          if (addr_last) begin
            if (is_last) st <= ST_IDLE;
            else         prod_q <= nxt_prod;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  hist_rmw #(.AW(ADDR_W), .DW(CNT_W)) u_rmw (
    .clk     (clk),
    .rst     (rst),
    .in_v    (ev_take),
    .in_addr (ev_bin),
    .in_bank (act_q),
    .rd_data (wr_bank ? bank_q[1] : bank_q[0]),
    .wr_v    (wr_v),
    .wr_bank (wr_bank),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              hit, we;
    logic [ADDR_W-1:0] wa, ra;
    logic [CNT_W-1:0]  wd;

    assign hit = wr_v && (wr_bank == 1'(b));
    assign we  = hit || (clr_we && ((st == ST_INIT) || (act_q != 1'(b))));
    assign wa  = hit ? wr_addr : addr_q;
    assign wd  = hit ? wr_data : '0;
    assign ra  = (act_q == 1'(b)) ? ev_bin : addr_q;

    hist_bank_ram #(.AW(ADDR_W), .DW(CNT_W)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (wa),
      .wdata (wd),
      .raddr (ra),
      .rdata (bank_q[b])
    );
  end

  hist_reducer #(.AW(ADDR_W), .DW(CNT_W), .SUM_W(SUM_W), .KW(KW), .PW(PW)) u_red (
    .clk       (clk),
    .rst       (rst),
    .rd_v      (emit),
    .rd_addr   (addr_q),
    .rd_prod   (prod_q),
    .rd_sumw   (cur_sumw),
    .rdata     (act_q ? bank_q[0] : bank_q[1]),
    .out_valid (out_valid),
    .out_prod  (out_prod),
    .out_index (out_index),
    .out_sum   (out_sum),
    .out_last  (out_last)
  );
endmodule

// File: rtl/hist_acc_chk.sv
module hist_acc_chk
  import hist_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input hst_state_e       st,
  input logic             act_q,
  input logic             cycle_swap,
  input logic             wr_v,
  input logic             wr_bank,
  input logic [CNT_W-1:0] wr_data,
  input logic             clr_we,
  input logic             out_valid,
  input logic             out_last
);
  // R3: a saturating increment never wraps to zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    wr_v |-> (wr_data != '0));

  // R4: an accepted swap exchanges the bank roles on the next edge
  p_swap_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && cycle_swap) |=> (act_q != $past(act_q)));

  // R9: a swap during readout or init leaves the active bank alone
  p_swap_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && cycle_swap) |=> $stable(act_q));

  // R5: the last marker only rides on a valid word
  p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R8: event writes never hit the bank being cleared
  p_no_clash_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SCAN && clr_we && wr_v) |-> (wr_bank == act_q));

  // R10: no product words while the banks are being initialised
  p_init_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INIT) |-> !out_valid);
endmodule

bind hist_pingpong_acc hist_acc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st         (st),
  .act_q      (act_q),
  .cycle_swap (cycle_swap),
  .wr_v       (wr_v),
  .wr_bank    (wr_bank),
  .wr_data    (wr_data),
  .clr_we     (clr_we),
  .out_valid  (out_valid),
  .out_last   (out_last)
);

// File: tb/sim_hist_pingpong_acc.sv
module sim_hist_pingpong_acc;
  localparam int DEPTH = 1024;
  localparam int MAXW  = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [9:0]  ev_bin = '0;
  logic        cycle_swap = 1'b0;
  logic [1:0]  prod_enable = 2'b01;
  logic [7:0]  prod_keep = {4'd10, 4'd10};
  logic        out_valid, out_last;
  logic [1:0]  out_prod;
  logic [9:0]  out_index;
  logic [23:0] out_sum;

  always #5 clk = ~clk;

  hist_pingpong_acc u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_bin(ev_bin),
    .cycle_swap(cycle_swap), .prod_enable(prod_enable), .prod_keep(prod_keep),
    .out_valid(out_valid), .out_prod(out_prod), .out_index(out_index),
    .out_sum(out_sum), .out_last(out_last)
  );

  int model [2][DEPTH];
  int act_m = 0;
  int busy_cnt = 0;
  int n_run = 0, n_fail = 0;
  int n_exp = 0, n_got = 0;
  int e_prod [MAXW], e_idx [MAXW], e_sum [MAXW], e_last [MAXW];
  int g_prod [MAXW], g_idx [MAXW], g_sum [MAXW], g_last [MAXW];

  always @(negedge clk) begin
    if (out_valid && n_got < MAXW) begin
      g_prod[n_got] = int'(out_prod);
      g_idx[n_got]  = int'(out_index);
      g_sum[n_got]  = int'(out_sum);
      g_last[n_got] = int'(out_last);
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_expected(input int bank);
    n_exp = 0;
    for (int p = 0; p < 2; p++) begin
      if (prod_enable[p]) begin
        int kw, sw;
        kw = int'(prod_keep[p*4 +: 4]);
        if (kw > 10) kw = 10;
        sw = 10 - kw;
        for (int i = 0; i < (1 << kw); i++) begin
          longint s;
          s = 0;
          for (int j = 0; j < (1 << sw); j++) s += model[bank][(i << sw) | j];
          if (s > 24'hFFFFFF) s = 24'hFFFFFF;
          e_prod[n_exp] = p;
          e_idx[n_exp]  = i;
          e_sum[n_exp]  = int'(s);
          e_last[n_exp] = (i == (1 << kw) - 1) ? 1 : 0;
          n_exp++;
        end
      end
    end
  endtask

  // one clock edge of stimulus; the model follows the requirements
  task automatic drive(input bit v, input int a, input bit sw);
    bit take;
    @(negedge clk);
    ev_valid   = v;
    ev_bin     = a[9:0];
    cycle_swap = sw;
    take = sw && (busy_cnt == 0);
    if (busy_cnt > 0) busy_cnt--;
    if (v && model[act_m][a] < 65535) model[act_m][a]++;
    if (take) begin
      int npass;
      build_expected(act_m);
      for (int k = 0; k < DEPTH; k++) model[act_m][k] = 0;
      act_m ^= 1;
      npass = (prod_enable == 2'b11) ? 2 : 1;
      busy_cnt = npass * DEPTH + 1;
      n_got = 0;
    end
  endtask

  task automatic compare_stream(input string req);
    chk(n_got == n_exp, req, n_got, n_exp);
    for (int i = 0; i < n_exp; i++) begin
      chk(g_sum[i] == e_sum[i], req, g_sum[i], e_sum[i]);
      chk(g_prod[i] == e_prod[i] && g_idx[i] == e_idx[i] && g_last[i] == e_last[i],
          req, g_prod[i] * 100000 + g_idx[i] * 10 + g_last[i],
          e_prod[i] * 100000 + e_idx[i] * 10 + e_last[i]);
    end
  endtask

  task automatic wait_done(input bit with_events, input string req);
    int n;
    n = busy_cnt + 4;
    for (int i = 0; i < n; i++) begin
      if (with_events && (i % 3 == 0)) drive(1'b1, (i * 37) % DEPTH, 1'b0);
      else drive(1'b0, 0, 1'b0);
    end
    compare_stream(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < 1100; i++) begin
      drive(1'b0, 0, 1'b0);
      if (out_valid) chk(1'b0, "R10 init out_valid", 1, 0);
    end
    chk(out_valid == 1'b0, "R10 idle out_valid", int'(out_valid), 0);
  endtask

  task automatic t_basic;
    prod_enable = 2'b01;
    prod_keep   = {4'd10, 4'd10};
    drive(1'b1, 3, 1'b0);   drive(1'b0, 0, 1'b0);
    drive(1'b1, 3, 1'b0);   drive(1'b0, 0, 1'b0);
    drive(1'b1, 100, 1'b0); drive(1'b0, 0, 1'b0);
    drive(1'b1, 1023, 1'b0);drive(1'b0, 0, 1'b0);
    drive(1'b0, 0, 1'b0);   drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R1 R10 spaced increments");
  endtask

  task automatic t_backtoback;
    int pat [10] = '{7, 7, 7, 7, 8, 7, 8, 7, 9, 9};
    prod_enable = 2'b01;
    prod_keep   = {4'd10, 4'd10};
    foreach (pat[i]) drive(1'b1, pat[i], 1'b0);
    drive(1'b1, 5, 1'b1);   // event in the swap cycle goes to the frozen bank
    wait_done(1'b1, "R2 R4 consecutive and swap-cycle events");
  endtask

  task automatic t_reduce;
    prod_enable = 2'b11;
    prod_keep   = {4'd0, 4'd4};
    drive(1'b0, 0, 1'b1);
    wait_done(1'b1, "R5 R8 reduced products after events during readout");
  endtask

  task automatic t_enable;
    prod_enable = 2'b10;
    prod_keep   = {4'd6, 4'd15};
    drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R6 only product 1 enabled");
    for (int i = 0; i < 40; i++) drive(1'b1, i * 25, 1'b0);
    prod_enable = 2'b00;
    drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R6 no product enabled");
  endtask

  task automatic t_clear;
    prod_enable = 2'b01;
    prod_keep   = {4'd10, 4'd10};
    drive(1'b1, 11, 1'b0);
    drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R7 bank holds only new events");
    drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R7 cleared bank reads zero");
  endtask

  task automatic t_sat;
    prod_enable = 2'b01;
    prod_keep   = {4'd10, 4'd10};
    for (int i = 0; i < 65540; i++) drive(1'b1, 200, 1'b0);
    drive(1'b1, 201, 1'b0);
    drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R3 saturation");
    chk(n_got > 200 && g_sum[200] == 65535, "R3 counter 200",
        (n_got > 200) ? g_sum[200] : -1, 65535);
  endtask

  task automatic t_busy_swap;
    prod_enable = 2'b01;
    prod_keep   = {4'd10, 4'd5};
    drive(1'b1, 42, 1'b0);
    drive(1'b0, 0, 1'b1);
    for (int i = 0; i < 300; i++) drive(1'b0, 0, 1'b0);
    drive(1'b1, 77, 1'b1);  // swap ignored, event still counted
    drive(1'b1, 78, 1'b1);
    wait_done(1'b0, "R9 readout not restarted");
    drive(1'b0, 0, 1'b1);
    wait_done(1'b0, "R9 active bank kept filling");
  endtask

  initial begin
    t_reset;
    t_basic;
    t_backtoback;
    t_reduce;
    t_enable;
    t_clear;
    t_sat;
    t_busy_swap;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule